// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block moves one byte over a single-wire serial link. The byte is shifted out most significant bit first. At the same time, one received bit per bit period enters at the least significant end. After eight bit periods the data register holds the received byte and the outgoing byte is gone. A control write with the start flag set launches the transfer. The busy flag then stays high until the eighth bit boundary. At that boundary the busy flag drops and a one-cycle interrupt request is issued.

Bit boundaries come from one of two sources:

- **Internal pacing.** A free-running cycle counter runs from reset. A boundary is declared in every cycle where the counter bit chosen by `PERIOD_SEL` differs from its value in the previous cycle. Boundaries are therefore spaced 2^`PERIOD_SEL` cycles apart. The counter is not aligned to the start of a transfer, so the first bit period can be shorter than the rest.
- **External pacing.** A boundary is declared in every cycle where `ext_strobe` is high.

The outgoing line idles high. When no partner drives the input (`sin_connected` low), ones are shifted in.

Top module: `sbyte_shifter`

## Requirements
- R1: After reset: `data_q` is 0, `ctrl_rdata` is 0, `sout` is 1, and `bit_start` and `irq` are 0.
- R2: A cycle with `ctrl_we` and `ctrl_start` high while idle starts a transfer. From the next cycle, busy (ctrl_rdata bit 7) is 1, `sout` shows the data register MSB, and `bit_start` pulses for that one cycle.
- R3: With internal pacing selected (ctrl_rdata bit 0 = 1), consecutive bit boundaries of a transfer are exactly 2^PERIOD_SEL cycles apart. With the default of 2 this is 4 cycles.
- R4: At every boundary the data register shifts left by one and the received bit enters bit 0. When `sin_connected` is 0 the received bit is 1. After a transfer, `data_q` therefore equals the byte received MSB first, or 0xFF when nothing was connected.
- R5: At each of the first seven boundaries, `sout` takes the next transmit bit in MSB-first order and `bit_start` pulses for one cycle.
- R6: The eighth boundary ends the transfer. In the following cycle busy is 0, `sout` is 1, and `irq` is high for exactly one cycle.
- R7: While idle, `data_q` changes only by a data write. `bit_start` stays 0 and `sout` stays 1 whatever ticks or strobes occur.
- R8: During a transfer, writes to the data register and to the control register are ignored.
- R9: With external pacing selected (ctrl_rdata bit 0 = 0), boundaries occur exactly in the cycles where `ext_strobe` is high, and internal ticks have no effect.
- R10: `ctrl_rdata` is {busy, six zero bits, clock select}. The clock select bit is loaded from `ctrl_int` by any control write made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_we | input | 1 | Data register write enable |
| data_wdata | input | DATA_W | Data register write value |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_start | input | 1 | Start flag carried by a control write |
| ctrl_int | input | 1 | Clock select carried by a control write (1 = internal) |
| ext_strobe | input | 1 | External bit-boundary strobe |
| sin | input | 1 | Serial data in |
| sin_connected | input | 1 | High when a partner drives `sin` |
| data_q | output | DATA_W | Data register |
| ctrl_rdata | output | 8 | Control readback: busy in bit 7, clock select in bit 0 |
| sout | output | 1 | Serial data out, idles high |
| bit_start | output | 1 | One-cycle pulse when a new bit is presented |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The assertions assume that `ext_strobe` matters only through the selected pacing source, and that writes are single-cycle pulses taken on a clock edge. They make no assumption about how writes line up with boundaries. The stimulus drives every input at the falling edge and never keeps a strobe high for more than one cycle. It deliberately issues data and control writes in the middle of transfers so that the ignore rules are exercised under the assertions. External strobes are spaced four cycles apart, which keeps the boundary timing of both pacing modes identical for the bench's interval check.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int CTRL_W       = 8;
    localparam int CTRL_BUSY_POS = 7;
    localparam int CTRL_SEL_POS  = 0;

    function automatic logic [CTRL_W-1:0] ctrl_pack(input logic busy, input logic int_sel);
        logic [CTRL_W-1:0] v;
        v = '0;
        v[CTRL_BUSY_POS] = busy;
        v[CTRL_SEL_POS]  = int_sel;
        return v;
    endfunction
endpackage

// File: rtl/sbs_tick_gen.sv
module sbs_tick_gen #(
    parameter int PERIOD_SEL = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = PERIOD_SEL + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             last;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.cnt  = s_q.cnt + 1'b1;
        s_d.last = s_q.cnt[PERIOD_SEL];
        tick     = s_q.cnt[PERIOD_SEL] ^ s_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (PERIOD_SEL > 0) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R3
        end
    endgenerate
endmodule

// File: rtl/sbs_bit_src.sv
module sbs_bit_src (
    input  logic int_sel,
    input  logic tick,
    input  logic ext_strobe,
    input  logic sin,
    input  logic sin_connected,
    output logic advance,
    output logic in_bit
);
    always_comb begin
        advance = int_sel ? tick : ext_strobe;
        in_bit  = sin_connected ? sin : 1'b1;
    end
endmodule

// File: rtl/sbs_shift_core.sv
module sbs_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_start,
    input  logic              ctrl_int,
    input  logic              advance,
    input  logic              in_bit,
    output logic [DATA_W-1:0] data_q,
    output logic              busy,
    output logic              int_sel,
    output logic              sout,
    output logic              bit_start,
    output logic              irq
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              int_sel;
        logic              sout;
        logic              bit_start;
        logic              irq;
    } core_st_t;

    core_st_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.bit_start = 1'b0;
        s_d.irq       = 1'b0;
        if (!s_q.busy) begin
            if (data_we) s_d.data = data_wdata;
            if (ctrl_we) begin
                s_d.int_sel = ctrl_int;
                if (ctrl_start) begin
                    s_d.busy      = 1'b1;
                    s_d.cnt       = '0;
                    s_d.sout      = data_we ? data_wdata[DATA_W-1] : s_q.data[DATA_W-1];
                    s_d.bit_start = 1'b1;
                end
            end
        end else if (advance) begin
            s_d.data = {s_q.data[DATA_W-2:0], in_bit};
            if (s_q.cnt == LAST_BIT) begin
                s_d.cnt  = '0;
                s_d.busy = 1'b0;
                s_d.sout = 1'b1;
                s_d.irq  = 1'b1;
            end else begin
                s_d.cnt       = s_q.cnt + 1'b1;
                s_d.sout      = s_q.data[DATA_W-2];
                s_d.bit_start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sout <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_q    = s_q.data;
    assign busy      = s_q.busy;
    assign int_sel   = s_q.int_sel;
    assign sout      = s_q.sout;
    assign bit_start = s_q.bit_start;
    assign irq       = s_q.irq;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> s_q.sout); // R7
    AST_IRQ_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> !s_q.busy); // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq); // R6
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !data_we) |=> $stable(s_q.data)); // R7
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !advance) |=> $stable(s_q.data)); // R8
    AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> s_q.bit_start); // R2
endmodule

// File: rtl/sbyte_shifter.sv
module sbyte_shifter #(
    parameter int DATA_W     = 8,
    parameter int PERIOD_SEL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ctrl_we,
    input  logic              ctrl_start,
    input  logic              ctrl_int,
    input  logic              ext_strobe,
    input  logic              sin,
    input  logic              sin_connected,
    output logic [DATA_W-1:0] data_q,
    output logic [7:0]        ctrl_rdata,
    output logic              sout,
    output logic              bit_start,
    output logic              irq
);
    import sbs_pkg::*;

    logic tick, advance, in_bit, busy, int_sel;

    sbs_tick_gen #(.PERIOD_SEL(PERIOD_SEL)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    sbs_bit_src u_src (
        .int_sel(int_sel), .tick(tick), .ext_strobe(ext_strobe),
        .sin(sin), .sin_connected(sin_connected),
        .advance(advance), .in_bit(in_bit)
    );

    sbs_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .data_we(data_we), .data_wdata(data_wdata),
        .ctrl_we(ctrl_we), .ctrl_start(ctrl_start), .ctrl_int(ctrl_int),
        .advance(advance), .in_bit(in_bit),
        .data_q(data_q), .busy(busy), .int_sel(int_sel),
        .sout(sout), .bit_start(bit_start), .irq(irq)
    );

    assign ctrl_rdata = ctrl_pack(busy, int_sel);

    AST_CTRL_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[7] |-> sout); // R10
endmodule

// File: tb/sbyte_shifter_tb.sv
`timescale 1ns/1ps
module sbyte_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_we = 0, ctrl_we = 0, ctrl_start = 0, ctrl_int = 0;
    logic [7:0] data_wdata = '0;
    logic       ext_strobe = 0, sin = 0, sin_connected = 0;
    logic [7:0] data_q, ctrl_rdata;
    logic       sout, bit_start, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sbyte_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .data_we(data_we), .data_wdata(data_wdata),
        .ctrl_we(ctrl_we), .ctrl_start(ctrl_start), .ctrl_int(ctrl_int),
        .ext_strobe(ext_strobe), .sin(sin), .sin_connected(sin_connected),
        .data_q(data_q), .ctrl_rdata(ctrl_rdata), .sout(sout),
        .bit_start(bit_start), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [7:0] tx, input logic [7:0] rx,
                            input bit conn, input bit ext, input bit poke);
        logic [7:0] exp_data;
        int k, last, cyc;
        bit done;
        exp_data = conn ? rx : 8'hFF;
        k = 0; last = -1; cyc = 0; done = 0;
        @(negedge clk); data_we = 1; data_wdata = tx;
        @(negedge clk); data_we = 0; sin = rx[7]; sin_connected = conn;
        ctrl_we = 1; ctrl_start = 1; ctrl_int = !ext;
        @(negedge clk); ctrl_we = 0; ctrl_start = 0;
        check(ctrl_rdata[7] && bit_start && sout == tx[7], "R2 start",
              {ctrl_rdata[7], bit_start, sout}, {2'b11, tx[7]});
        while (!done && cyc < 400) begin
            @(negedge clk); cyc++;
            ext_strobe = ext && (cyc % 4 == 0);
            data_we = 0; ctrl_we = 0;
            if (poke && cyc == 6) begin
                data_we = 1; data_wdata = ~tx;
                ctrl_we = 1; ctrl_start = 0; ctrl_int = ext;
            end
            if (poke && cyc == 7)
                check(ctrl_rdata == {1'b1, 6'b0, !ext}, "R8 ctrl write ignored",
                      ctrl_rdata, {1'b1, 6'b0, !ext});
            if (bit_start) begin
                k++;
                if (k <= 7) check(sout == tx[7-k], "R5 bit out", sout, tx[7-k]);
                if (last >= 0)
                    check(cyc - last == 4, ext ? "R9 strobe spacing" : "R3 tick spacing",
                          cyc - last, 4);
                last = cyc;
                if (k <= 7) sin = rx[7-k];
            end
            if (irq) begin
                done = 1;
                check(k == 7, "R6 eight boundaries", k + 1, 8);
                check(!ctrl_rdata[7] && sout, "R6 end state", {ctrl_rdata[7], sout}, 2'b01);
                check(data_q == exp_data, conn ? "R4 received byte" : "R4 ones shifted",
                      data_q, exp_data);
            end
        end
        if (!done) check(0, "R6 completion", 0, 1);
        data_we = 0; ctrl_we = 0;
        @(negedge clk); ext_strobe = 0;
        check(!irq, "R6 irq single pulse", irq, 0);
    endtask

    initial begin
        logic [7:0] hold;
        bit idle_ok;
        repeat (3) @(negedge clk);
        check(data_q == 0 && ctrl_rdata == 0 && sout && !bit_start && !irq, "R1 reset",
              {data_q, ctrl_rdata, sout, bit_start, irq}, 19'h4);
        rst_n = 1;
        @(negedge clk); ctrl_we = 1; ctrl_start = 0; ctrl_int = 1;
        @(negedge clk); ctrl_we = 0;
        check(ctrl_rdata == 8'h01, "R10 select readback", ctrl_rdata, 8'h01);

        run_xfer(8'h00, 8'hFF, 1, 0, 0);
        run_xfer(8'hFF, 8'h00, 1, 1, 0);
        for (int i = 0; i < 16; i++) begin
            run_xfer(8'(i * 29) ^ 8'hA5, ~8'(i * 53), (i % 3) != 0, i[0], i[1]);
        end

        hold = data_q;
        idle_ok = 1;
        ctrl_int = 1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            ext_strobe = (c % 3 == 0);
            if (bit_start || !sout || data_q != hold) idle_ok = 0;
        end
        ext_strobe = 0;
        check(idle_ok, "R7 idle no shift", data_q, hold);
        check(ctrl_rdata == 8'h00, "R10 idle readback", ctrl_rdata, 8'h00);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule